// File: doc/BRIEF.md
# Phase-Frequency Detector with Lock Qualification

This block sits in a frequency synthesizer between the two divider outputs and the charge pump. It watches the rising edges of the divided reference and the divided feedback, raises a pump-up or pump-down request for as long as one edge leads the other, and releases both requests together once both edges have arrived. Coincident edges still produce a one-cycle pulse on both requests, so there is no dead zone around zero phase error.

Everything is sampled by a fast clock that stands in for the crystal clock, so phase error is measured in whole periods of that clock. Lock is declared only after a run of aligned reference cycles in a row. A single misaligned cycle drops it at once. Four static control bits set the pump behaviour and the status pin. One bit swaps the sense of the up and down requests. One bit parks the pump outputs for open-loop modulation. A two-bit selector routes the lock flag, either divided clock or a constant high to the shared status pin. The pump-current choice is only passed on as a flag.

Top module: `pfd_lock_top`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `pump_up` and `pump_dn` are 0, `pump_en` is 1, `icp_hi_flag` is 0 and `ld_out` is 0.
- R2: With `pol_inv` = 0, when the reference rises d cycles before the feedback (d ≥ 1), `pump_up` is high for d+1 cycles and `pump_dn` for 1 cycle, and both fall together.
- R3: With `pol_inv` = 0, when the feedback rises d cycles before the reference, `pump_dn` is high for d+1 cycles and `pump_up` for 1 cycle.
- R4: When both rise in the same sampling cycle, `pump_up` and `pump_dn` are each high for exactly one cycle (no dead zone).
- R5: With `pol_inv` = 1, the roles of `pump_up` and `pump_dn` in R2 to R4 are swapped.
- R6: With `pump_hiz` = 1, `pump_up`, `pump_dn` and `pump_en` stay 0 whatever the edges do. Clearing it brings back closed-loop pulses and `pump_en` = 1.
- R7: The lock flag is set after more than three aligned reference cycles in a row, that is on the fourth, and not after three. A cycle is aligned when its error is below one sampling-clock period.
- R8: Any reference cycle with an error of one sampling period or more clears the lock flag at once and restarts the count. Four more aligned cycles are then needed.
- R9: `ld_sel` drives `ld_out`: 2'b00 gives the lock flag, 2'b01 gives `fb_in`, 2'b10 gives `ref_in`, 2'b11 gives constant 1.
- R10: `icp_hi_flag` follows `icp_hi` one cycle later (0 = low, nominal 1.5 mA; 1 = high, nominal 4.5 mA).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock (crystal stand-in) |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Divided reference clock |
| fb_in | input | 1 | Divided feedback clock |
| pol_inv | input | 1 | 1 swaps up and down requests |
| icp_hi | input | 1 | Pump current select: 0 low, 1 high |
| pump_hiz | input | 1 | 1 forces pump outputs off (open loop) |
| ld_sel | input | 2 | Status pin source select |
| pump_up | output | 1 | Pump-up request |
| pump_dn | output | 1 | Pump-down request |
| pump_en | output | 1 | Pump output drive enable |
| icp_hi_flag | output | 1 | Registered current-select flag |
| ld_out | output | 1 | Shared lock / test status pin |

## Verification
On every cycle the assertions check four things. The pump is silent while parked. A lone pending request holds until the other edge arrives. A misaligned cycle leaves the lock flag low on the next cycle. The flag only rises right after a completed pair. How many cycles the requests are high for a given lead, the polarity swap, the exact fourth-cycle lock point, the restart after a bad cycle and each status-pin selection can only be shown by the bench's timed edge patterns.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    typedef enum logic [1:0] {
        LD_LOCK = 2'b00,
        LD_FB   = 2'b01,
        LD_REF  = 2'b10,
        LD_HIGH = 2'b11
    } ld_sel_e;

    typedef struct packed {
        logic    pol_inv;
        logic    icp_hi;
        logic    hiz;
        ld_sel_e ld_sel;
    } ctrl_t;

    typedef struct packed {
        logic up;
        logic dn;
        logic en;
    } pump_t;

    localparam int NUM_CLK_IN = 2;
    localparam int IDX_REF    = 0;
    localparam int IDX_FB     = 1;

    function automatic pump_t map_pump(input logic up_q, input logic dn_q,
                                       input ctrl_t c);
        pump_t p;
        p.en = ~c.hiz;
        if (c.hiz) begin
            p.up = 1'b0;
            p.dn = 1'b0;
        end else if (c.pol_inv) begin
            p.up = dn_q;
            p.dn = up_q;
        end else begin
            p.up = up_q;
            p.dn = dn_q;
        end
        return p;
    endfunction

endpackage

// File: rtl/pfd_edge.sv
module pfd_edge (
    input  logic clk,
    input  logic rst,
    input  logic sig_in,
    output logic rise
);
    logic sig_d;

    always_ff @(posedge clk) begin
        if (rst) sig_d <= 1'b1;
        else     sig_d <= sig_in;
    end

    assign rise = sig_in & ~sig_d;
endmodule

// File: rtl/pfd_core.sv
module pfd_core (
    input  logic clk,
    input  logic rst,
    input  logic ref_rise,
    input  logic fb_rise,
    output logic up_q,
    output logic dn_q
);
    logic both;
    assign both = up_q & dn_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            up_q <= 1'b0;
            dn_q <= 1'b0;
        end else if (both) begin
            up_q <= ref_rise;
            dn_q <= fb_rise;
        end else begin
            up_q <= up_q | ref_rise;
            dn_q <= dn_q | fb_rise;
        end
    end

    // R2: a lone up request holds until the feedback edge arrives
    p_up_holds_r2: assert property (@(posedge clk) disable iff (rst)
        (up_q && !dn_q && !fb_rise) |=> up_q);

    // R3: a lone down request holds until the reference edge arrives
    p_dn_holds_r3: assert property (@(posedge clk) disable iff (rst)
        (dn_q && !up_q && !ref_rise) |=> dn_q);
endmodule

// File: rtl/pfd_lockmon.sv
module pfd_lockmon #(
    parameter int ERR_LIMIT = 1,
    parameter int LOCK_RUN  = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic up_q,
    input  logic dn_q,
    output logic lock_q
);
    localparam int ERR_W  = $clog2(ERR_LIMIT + 1);
    localparam int RUN_W  = $clog2(LOCK_RUN + 1);

    logic [ERR_W-1:0] err_cnt;
    logic [RUN_W-1:0] good_cnt;
    logic             one_side;
    logic             pair_done;
    logic             bad;
    logic             good;

    assign one_side  = up_q ^ dn_q;
    assign pair_done = up_q & dn_q;
    assign bad       = one_side && ((int'(err_cnt) + 1) >= ERR_LIMIT);
    assign good      = pair_done && (int'(err_cnt) < ERR_LIMIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            err_cnt <= '0;
        end else if (pair_done) begin
            err_cnt <= '0;
        end else if (one_side && (int'(err_cnt) < ERR_LIMIT)) begin
            err_cnt <= err_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            good_cnt <= '0;
            lock_q   <= 1'b0;
        end else if (bad) begin
            good_cnt <= '0;
            lock_q   <= 1'b0;
        end else if (good) begin
            if (int'(good_cnt) >= LOCK_RUN - 1) begin
                lock_q   <= 1'b1;
                good_cnt <= RUN_W'(LOCK_RUN);
            end else begin
                good_cnt <= good_cnt + 1'b1;
            end
        end
    end

    // R8: a misaligned cycle leaves the lock flag low afterwards
    p_bad_unlocks_r8: assert property (@(posedge clk) disable iff (rst)
        bad |=> !lock_q);

    // R7: lock only rises right after a completed edge pair
    p_lock_after_pair_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(lock_q) |-> $past(pair_done));

    p_run_bound_r7: assert property (@(posedge clk) disable iff (rst)
        int'(good_cnt) <= LOCK_RUN);
endmodule

// File: rtl/pfd_lock_top.sv
module pfd_lock_top #(
    parameter int ERR_LIMIT = 1,
    parameter int LOCK_RUN  = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ref_in,
    input  logic       fb_in,
    input  logic       pol_inv,
    input  logic       icp_hi,
    input  logic       pump_hiz,
    input  logic [1:0] ld_sel,
    output logic       pump_up,
    output logic       pump_dn,
    output logic       pump_en,
    output logic       icp_hi_flag,
    output logic       ld_out
);
    import pfd_pkg::*;

    ctrl_t ctrl_q;
    pump_t pump;
    logic [NUM_CLK_IN-1:0] raw_in;
    logic [NUM_CLK_IN-1:0] rise;
    logic up_q, dn_q, lock_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '{pol_inv: 1'b0, icp_hi: 1'b0, hiz: 1'b0, ld_sel: LD_LOCK};
        end else begin
            ctrl_q.pol_inv <= pol_inv;
            ctrl_q.icp_hi  <= icp_hi;
            ctrl_q.hiz     <= pump_hiz;
            ctrl_q.ld_sel  <= ld_sel_e'(ld_sel);
        end
    end

    assign raw_in[IDX_REF] = ref_in;
    assign raw_in[IDX_FB]  = fb_in;

    for (genvar g = 0; g < NUM_CLK_IN; g++) begin : g_edge
        pfd_edge u_edge (
            .clk    (clk),
            .rst    (rst),
            .sig_in (raw_in[g]),
            .rise   (rise[g])
        );
    end

    pfd_core u_core (
        .clk      (clk),
        .rst      (rst),
        .ref_rise (rise[IDX_REF]),
        .fb_rise  (rise[IDX_FB]),
        .up_q     (up_q),
        .dn_q     (dn_q)
    );

    pfd_lockmon #(.ERR_LIMIT(ERR_LIMIT), .LOCK_RUN(LOCK_RUN)) u_lock (
        .clk    (clk),
        .rst    (rst),
        .up_q   (up_q),
        .dn_q   (dn_q),
        .lock_q (lock_q)
    );

    assign pump        = map_pump(up_q, dn_q, ctrl_q);
    assign pump_up     = pump.up;
    assign pump_dn     = pump.dn;
    assign pump_en     = pump.en;
    assign icp_hi_flag = ctrl_q.icp_hi;

    always_comb begin
        unique case (ctrl_q.ld_sel)
            LD_LOCK: ld_out = lock_q;
            LD_FB:   ld_out = fb_in;
            LD_REF:  ld_out = ref_in;
            default: ld_out = 1'b1;
        endcase
    end

    // R6: parked pump stays silent even with a pending request
    p_hiz_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.hiz && (up_q || dn_q)) |-> (!pump_up && !pump_dn && !pump_en));
endmodule

// File: tb/test_pfd_lock_top.sv
module test_pfd_lock_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_in = 1'b0, fb_in = 1'b0;
    logic pol_inv = 1'b0, icp_hi = 1'b0, pump_hiz = 1'b0;
    logic [1:0] ld_sel = 2'b00;
    logic pump_up, pump_dn, pump_en, icp_hi_flag, ld_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pfd_lock_top i_pfd_lock_top (
        .clk(clk), .rst(rst), .ref_in(ref_in), .fb_in(fb_in),
        .pol_inv(pol_inv), .icp_hi(icp_hi), .pump_hiz(pump_hiz),
        .ld_sel(ld_sel), .pump_up(pump_up), .pump_dn(pump_dn),
        .pump_en(pump_en), .icp_hi_flag(icp_hi_flag), .ld_out(ld_out)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; ref_in = 1'b0; fb_in = 1'b0;
        wait_cyc(2);
        @(negedge clk);
        rst = 1'b0;
        wait_cyc(2);
    endtask

    // one 16-cycle reference period; counts cycles each pump output is high
    task automatic run_period(input int ref_at, input int fb_at,
                              output int nup, output int ndn, output int nen);
        nup = 0; ndn = 0; nen = 0;
        for (int t = 0; t < 16; t++) begin
            @(negedge clk);
            ref_in = (t >= ref_at) && (t < ref_at + 8);
            fb_in  = (t >= fb_at)  && (t < fb_at + 8);
            @(posedge clk); #1;
            nup += int'(pump_up);
            ndn += int'(pump_dn);
            nen += int'(pump_en);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1; pol_inv = 0; icp_hi = 0; pump_hiz = 0; ld_sel = 2'b00;
        wait_cyc(2);
        check("R1 up", pump_up, 0);
        check("R1 dn", pump_dn, 0);
        check("R1 en", pump_en, 1);
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #1;
        check("R1 ld", ld_out, 0);
        check("R1 icp", icp_hi_flag, 0);
    endtask

    task automatic t_leads();
        int u, d, e;
        do_reset();
        run_period(2, 5, u, d, e);
        check("R2 up cycles", u, 4);
        check("R2 dn cycles", d, 1);
        run_period(6, 4, u, d, e);
        check("R3 dn cycles", d, 3);
        check("R3 up cycles", u, 1);
        run_period(3, 3, u, d, e);
        check("R4 up cycles", u, 1);
        check("R4 dn cycles", d, 1);
    endtask

    task automatic t_polarity();
        int u, d, e;
        @(negedge clk); pol_inv = 1'b1;
        do_reset();
        run_period(2, 5, u, d, e);
        check("R5 dn from ref lead", d, 4);
        check("R5 up from ref lead", u, 1);
        @(negedge clk); pol_inv = 1'b0;
        wait_cyc(2);
    endtask

    task automatic t_hiz();
        int u, d, e;
        @(negedge clk); pump_hiz = 1'b1;
        do_reset();
        run_period(1, 6, u, d, e);
        check("R6 up parked", u, 0);
        check("R6 dn parked", d, 0);
        check("R6 en parked", e, 0);
        @(negedge clk); pump_hiz = 1'b0;
        wait_cyc(2);
        run_period(1, 3, u, d, e);
        check("R6 up restored", u, 3);
        check("R6 en restored", e, 16);
    endtask

    task automatic t_lock();
        int u, d, e;
        @(negedge clk); ld_sel = 2'b00;
        do_reset();
        for (int k = 0; k < 3; k++) run_period(2, 2, u, d, e);
        check("R7 no lock after 3", ld_out, 0);
        run_period(2, 2, u, d, e);
        check("R7 lock after 4", ld_out, 1);
        run_period(2, 3, u, d, e);
        check("R8 one-cycle error drops lock", ld_out, 0);
        for (int k = 0; k < 3; k++) run_period(2, 2, u, d, e);
        check("R8 restart needs more", ld_out, 0);
        run_period(2, 2, u, d, e);
        check("R8 relock on fourth", ld_out, 1);
    endtask

    task automatic t_ldmux();
        do_reset();
        @(negedge clk); ld_sel = 2'b11; wait_cyc(2);
        check("R9 sel11 high", ld_out, 1);
        @(negedge clk); ld_sel = 2'b01; wait_cyc(2);
        @(negedge clk); fb_in = 1'b1; #1;
        check("R9 sel01 fb high", ld_out, 1);
        @(negedge clk); fb_in = 1'b0; #1;
        check("R9 sel01 fb low", ld_out, 0);
        @(negedge clk); ld_sel = 2'b10; wait_cyc(2);
        @(negedge clk); ref_in = 1'b1; #1;
        check("R9 sel10 ref high", ld_out, 1);
        @(negedge clk); ref_in = 1'b0; #1;
        check("R9 sel10 ref low", ld_out, 0);
        @(negedge clk); ld_sel = 2'b00; wait_cyc(2);
        check("R9 sel00 lock low", ld_out, 0);
    endtask

    task automatic t_icp();
        @(negedge clk); icp_hi = 1'b1;
        @(posedge clk); #1;
        check("R10 flag high", icp_hi_flag, 1);
        @(negedge clk); icp_hi = 1'b0;
        @(posedge clk); #1;
        check("R10 flag low", icp_hi_flag, 0);
    endtask

    initial begin
        t_reset();
        t_leads();
        t_polarity();
        t_hiz();
        t_lock();
        t_ldmux();
        t_icp();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual 0 expected 1 (run finished)");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule